// File: doc/BRIEF.md
# Conditional Branch Test Unit

This block decides whether an 8-bit processor takes a relative branch. For each request it reads five inputs: an opcode from the branch family, the displacement byte, the 5-bit status word, the 6-bit indirect scratchpad address register and the program counter. The program counter input holds the address of the displacement byte. One clock later the block returns four results: a flag that says whether the opcode belongs to the family, a taken flag, the next program counter and the number of cycles the branch costs.

The low opcode bits form a single condition mask. A branch-on-true opcode takes the branch when any flag selected by the mask is set. A branch-on-false opcode takes the branch when every selected flag is clear. A separate opcode tests the low three bits of the indirect address register. A taken branch adds the sign-extended displacement to the address of the displacement byte. A branch that is not taken steps past that byte.

Top module: `brtest_unit`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid`, `res_hit`, `res_taken`, `res_next_pc` and `res_cycles` are all zero until the first request is accepted.
- R2: `res_valid` equals `req_valid` from the previous clock. Each request produces its result exactly one cycle later.
- R3: The status word uses bit 0 = sign (set when a result is positive), bit 1 = carry, bit 2 = zero, bit 3 = overflow and bit 4 = interrupt control. Opcodes 0x80 to 0x87 take the branch when status[2:0] AND opcode[2:0] is nonzero.
- R4: Opcodes 0x90 to 0x9F take the branch when status[3:0] AND opcode[3:0] is zero. Status bit 4 never affects any outcome.
- R5: Opcode 0x80 is never taken, whatever the status. Opcode 0x90 is always taken.
- R6: Opcode 0x8F is taken unless the indirect register bits [2:0] equal 7. Bits [5:3] of the indirect register have no effect.
- R7: When the branch is taken, `res_next_pc` equals `req_pc` plus the sign-extended displacement, modulo 2^PC_W.
- R8: When a family opcode is not taken, `res_next_pc` equals `req_pc + 1`, modulo 2^PC_W.
- R9: `res_cycles` equals TAKEN_CYCLES (default 4) for a taken branch and SKIP_CYCLES (default 3) for a family opcode that is not taken.
- R10: Any opcode outside 0x80–0x87, 0x8F and 0x90–0x9F gives `res_hit` = 0, `res_taken` = 0, `res_cycles` = 0 and `res_next_pc` = `req_pc`.
- R11: While `req_valid` is low, `res_hit`, `res_taken`, `res_next_pc` and `res_cycles` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_opcode | input | 8 | Opcode under test |
| req_disp | input | 8 | Displacement byte, two's complement |
| req_status | input | 5 | Status word |
| req_isar | input | 6 | Indirect scratchpad address register |
| req_pc | input | PC_W | Address of the displacement byte |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Opcode belongs to the branch family |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | PC_W | Next program counter |
| res_cycles | output | CYC_W | Cycle cost of the branch |

## Verification
Assertions check five things on every cycle:
- the one-cycle valid latency;
- that results are held while no request arrives;
- the fixed outcomes of the two mask-zero opcodes;
- the not-taken target;
- the quiet result for opcodes outside the family.

The bench sweeps every family opcode against all 32 status words. It also covers the full range of the indirect register and all opcodes outside the family. Only these scenarios show the mask semantics of the true and false groups, that bit 4 is ignored, the taken target arithmetic with wrap-around, and the cycle counts. The bench checks each of these against arithmetic it computes itself.

// File: rtl/brtest_pkg.sv
package brtest_pkg;

    // Bit positions within the status word.
    localparam int FLG_SIGN  = 0;
    localparam int FLG_CARRY = 1;
    localparam int FLG_ZERO  = 2;
    localparam int FLG_OVF   = 3;
    localparam int FLG_ICB   = 4;

    typedef enum logic [1:0] {
        BK_NONE  = 2'd0,
        BK_TRUE  = 2'd1,
        BK_FALSE = 2'd2,
        BK_ISAR  = 2'd3
    } br_kind_e;

endpackage

// File: rtl/brtest_decode.sv
module brtest_decode
    import brtest_pkg::*;
(
    input  logic [7:0] opcode,
    output br_kind_e   kind,
    output logic [3:0] mask
);
    always_comb begin
        kind = BK_NONE;
        mask = 4'd0;
        if (opcode[7:4] == 4'h9) begin
            kind = BK_FALSE;
            mask = opcode[3:0];
        end else if (opcode == 8'h8F) begin
            kind = BK_ISAR;
        end else if (opcode[7:3] == 5'b10000) begin
            kind = BK_TRUE;
            mask = {1'b0, opcode[2:0]};
        end
    end
endmodule

// File: rtl/brtest_cond.sv
module brtest_cond
    import brtest_pkg::*;
(
    input  br_kind_e   kind,
    input  logic [3:0] mask,
    input  logic [4:0] status,
    input  logic [5:0] isar,
    output logic       taken
);
    logic [3:0] sel;

    // The interrupt-control bit is never part of a test.
    assign sel = status[FLG_OVF:FLG_SIGN] & mask;

    always_comb begin
        unique case (kind)
            BK_TRUE:  taken = (sel != 4'd0);
            BK_FALSE: taken = (sel == 4'd0);
            BK_ISAR:  taken = (isar[2:0] != 3'b111);
            default:  taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/brtest_target.sv
module brtest_target #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    input  logic              hit,
    input  logic              taken,
    output logic [PC_W-1:0]   next_pc
);
    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] jump_pc;
    logic [PC_W-1:0] skip_pc;

    generate
        if (EXT_W > 0) begin : g_ext
            assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[PC_W-1:0];
        end
    endgenerate

    assign jump_pc = pc + disp_ext;
    assign skip_pc = pc + PC_W'(1);

    always_comb begin
        if (!hit)       next_pc = pc;
        else if (taken) next_pc = jump_pc;
        else            next_pc = skip_pc;
    end
endmodule

// File: rtl/brtest_unit.sv
module brtest_unit
    import brtest_pkg::*;
#(
    parameter int PC_W         = 16,
    parameter int DISP_W       = 8,
    parameter int TAKEN_CYCLES = 4,
    parameter int SKIP_CYCLES  = 3,
    localparam int CYC_MAX     = (TAKEN_CYCLES > SKIP_CYCLES) ? TAKEN_CYCLES : SKIP_CYCLES,
    localparam int CYC_W       = $clog2(CYC_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [7:0]        req_opcode,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [4:0]        req_status,
    input  logic [5:0]        req_isar,
    input  logic [PC_W-1:0]   req_pc,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_taken,
    output logic [PC_W-1:0]   res_next_pc,
    output logic [CYC_W-1:0]  res_cycles
);
    typedef struct packed {
        logic             vld;
        logic             hit;
        logic             taken;
        logic [PC_W-1:0]  npc;
        logic [CYC_W-1:0] cyc;
    } res_t;

    br_kind_e        kind;
    logic [3:0]      mask;
    logic            cond_taken;
    logic            hit;
    logic [PC_W-1:0] tgt_pc;
    res_t            st_d, st_q;

    brtest_decode u_decode (
        .opcode (req_opcode),
        .kind   (kind),
        .mask   (mask)
    );

    brtest_cond u_cond (
        .kind   (kind),
        .mask   (mask),
        .status (req_status),
        .isar   (req_isar),
        .taken  (cond_taken)
    );

    assign hit = (kind != BK_NONE);

    brtest_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_target (
        .pc      (req_pc),
        .disp    (req_disp),
        .hit     (hit),
        .taken   (cond_taken),
        .next_pc (tgt_pc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.hit   = hit;
            st_d.taken = cond_taken;
            st_d.npc   = tgt_pc;
            if (!hit)            st_d.cyc = '0;
            else if (cond_taken) st_d.cyc = CYC_W'(TAKEN_CYCLES);
            else                 st_d.cyc = CYC_W'(SKIP_CYCLES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid   = st_q.vld;
    assign res_hit     = st_q.hit;
    assign res_taken   = st_q.taken;
    assign res_next_pc = st_q.npc;
    assign res_cycles  = st_q.cyc;

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == $past(req_valid));

    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> ($stable(res_next_pc) && $stable(res_taken) && $stable(res_cycles)));

    a_r5_never_80: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_opcode == 8'h80) |-> (res_hit && !res_taken));

    a_r5_always_90: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_opcode == 8'h90) |-> (res_hit && res_taken));

    a_r8_skip_target: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit && !res_taken) |-> (res_next_pc == $past(req_pc) + PC_W'(1)));

    a_r10_quiet_other: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (!res_taken && res_cycles == '0 && res_next_pc == $past(req_pc)));
endmodule

// File: tb/tb_brtest_unit.sv
module tb_brtest_unit;
    localparam int PC_W = 16;
    localparam int TK   = 4;
    localparam int SK   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_opcode = '0;
    logic [7:0]  req_disp = '0;
    logic [4:0]  req_status = '0;
    logic [5:0]  req_isar = '0;
    logic [15:0] req_pc = '0;
    logic        res_valid, res_hit, res_taken;
    logic [15:0] res_next_pc;
    logic [2:0]  res_cycles;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    brtest_unit #(.PC_W(PC_W), .TAKEN_CYCLES(TK), .SKIP_CYCLES(SK)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_disp(req_disp), .req_status(req_status), .req_isar(req_isar),
        .req_pc(req_pc), .res_valid(res_valid), .res_hit(res_hit),
        .res_taken(res_taken), .res_next_pc(res_next_pc), .res_cycles(res_cycles)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one request, then check the registered result one cycle later.
    task automatic run(input logic [7:0] op, input logic [7:0] d, input logic [4:0] st,
                       input logic [5:0] is, input logic [15:0] pc);
        logic hit, tk;
        logic [15:0] npc;
        logic [2:0] cyc;
        string tag;
        hit = 1'b0; tk = 1'b0; tag = "R10";
        if (op >= 8'h80 && op <= 8'h87) begin
            hit = 1'b1; tk = ((st % 8) & (op % 8)) != 0;
            tag = (op == 8'h80) ? "R5" : "R3";
        end else if (op >= 8'h90 && op <= 8'h9F) begin
            hit = 1'b1; tk = ((st % 16) & (op % 16)) == 0;
            tag = (op == 8'h90) ? "R5" : "R4";
        end else if (op == 8'h8F) begin
            hit = 1'b1; tk = (is % 8) != 7; tag = "R6";
        end
        if (!hit)    npc = pc;
        else if (tk) npc = 16'((int'(pc) + int'($signed(d))) % 65536);
        else         npc = 16'((int'(pc) + 1) % 65536);
        cyc = !hit ? 3'd0 : (tk ? 3'(TK) : 3'(SK));
        @(negedge clk);
        req_valid = 1'b1; req_opcode = op; req_disp = d; req_status = st;
        req_isar = is; req_pc = pc;
        @(negedge clk);
        check("R2 valid", {31'd0, res_valid}, 32'd1);
        check({tag, " hit"}, {31'd0, res_hit}, {31'd0, hit});
        check({tag, " taken"}, {31'd0, res_taken}, {31'd0, tk});
        check(tk ? "R7 next_pc" : (hit ? "R8 next_pc" : "R10 next_pc"),
              {16'd0, res_next_pc}, {16'd0, npc});
        check(hit ? "R9 cycles" : "R10 cycles", {29'd0, res_cycles}, {29'd0, cyc});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {31'd0, res_valid}, 0);
        check("R1 taken", {31'd0, res_taken}, 0);
        check("R1 next_pc", {16'd0, res_next_pc}, 0);
        check("R1 cycles", {29'd0, res_cycles}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 hit", {31'd0, res_hit}, 0);

        // R3 R4 R5: every family opcode against every status word, bit 4 included
        for (int op = 8'h80; op <= 8'h9F; op++) begin
            if (op >= 8'h88 && op <= 8'h8F) continue;
            for (int st = 0; st < 32; st++)
                run(8'(op), 8'((st * 37 + op) % 256), 5'(st), 6'(st), 16'(16'hFFC0 + st * 3));
        end
        // R6: full indirect register range
        for (int is = 0; is < 64; is++)
            run(8'h8F, 8'(256 - is), 5'(is % 32), 6'(is), 16'(is * 1021));
        // R7 wrap-around in both directions
        run(8'h90, 8'h7F, 5'd0, 6'd0, 16'hFFF0);
        run(8'h90, 8'h80, 5'd0, 6'd0, 16'h0010);
        // R8 skip past end of address space
        run(8'h80, 8'h10, 5'd31, 6'd0, 16'hFFFF);
        // R10 all opcodes outside the family
        for (int op = 0; op < 256; op++) begin
            if ((op >= 8'h80 && op <= 8'h87) || op == 8'h8F || (op >= 8'h90 && op <= 8'h9F))
                continue;
            run(8'(op), 8'h55, 5'(op % 32), 6'(op % 64), 16'(op * 257));
        end
        // R2 / R11: idle cycles drop valid and hold results
        run(8'h84, 8'h20, 5'b00100, 6'd0, 16'h1000);
        held = res_next_pc;
        @(negedge clk);
        req_valid = 1'b0; req_opcode = 8'h90; req_pc = 16'h2222;
        @(negedge clk);
        check("R2 idle valid", {31'd0, res_valid}, 0);
        check("R11 hold next_pc", {16'd0, res_next_pc}, {16'd0, held});
        check("R11 hold taken", {31'd0, res_taken}, 1);
        check("R11 hold cycles", {29'd0, res_cycles}, TK);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule